// File: doc/BRIEF.md
# Two-Level Lookahead Carry Adder

This block adds two 16-bit operands and a carry-in, giving a 16-bit sum and a carry-out, with no clock and no stored state. Every output is a function of the current inputs alone. The adder is split into sixteen bit cells and a tree of lookahead carry units that all share one design.

Each bit cell forms a generate term (both operand bits set) and a propagate term (the two operand bits differ). It has no carry output. It takes its carry from the lookahead logic and forms its sum from that carry. Four first-level lookahead units each serve one nibble. Each one computes the carries inside its nibble from fully expanded sum-of-products terms, and also forms a group propagate and a group generate. A second-level unit of the same design takes the four group pairs and the external carry-in. From these it produces the carries into nibbles 1 to 3 and the final carry-out.

The group propagate and generate of the second-level unit are brought out to ports. A wider adder can then cascade several of these blocks through one more lookahead level.

Top module: `cla_adder16`

## Requirements
- R1: In each bit cell, generate is a AND b and propagate is a XOR b, so the two are never high together.
- R2: Sum bit i equals propagate i XOR the carry into bit i. That carry comes from the lookahead logic, not from the cell below.
- R3: A lookahead unit forms each carry c(k) as the OR over every earlier position j of g(j) ANDed with all propagates above j. It also ORs in the carry-in ANDed with all propagates below k. The result matches the recursion c(k+1) = g(k) | p(k)&c(k), but no carry is built from an earlier carry.
- R4: The group propagate of a unit is the AND of its four propagate inputs. The port `grp_prop` is 1 exactly when op_a XOR op_b is 16'hFFFF.
- R5: The group generate of a unit is g3 | p3&g2 | p3&p2&g1 | p3&p2&p1&g0. The port `grp_gen` equals the carry-out of op_a + op_b with a carry-in of 0.
- R6: The second-level unit has the same design as the first level. Its carries feed nibbles 1, 2 and 3, and its top carry is `carry_out`. The external carry-in feeds both nibble 0 and the second-level unit. Each nibble's own internal carry-out agrees with the second-level carry into the next nibble.
- R7: For every input, {carry_out, sum_out} equals op_a + op_b + carry_in as a 17-bit value.
- R8: The worst-case ripple patterns give the correct result. These are 16'h000F + 16'h0001 (sum 16'h0010), 16'hFFFF + 16'h0001 (sum 0, carry-out 1) and 16'hFFFF + 16'hFFFF with carry-in 1 (sum 16'hFFFF, carry-out 1).
- R9: The block has no clock and holds no state. Outputs settle after an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_prop | output | 1 | Group propagate of the whole 16 bits, for cascading |
| grp_gen | output | 1 | Group generate of the whole 16 bits, for cascading |

## Verification
The block has no internal state, so any wrong internal term shows up at the ports in the same time step as the input change. A wrong bit propagate or generate gives wrong sum bits or a wrong group output. A wrong lookahead product term gives a wrong carry into a nibble. That error shows as a corrupted low bit of the next nibble, or as a wrong carry-out, when an operand pattern runs a carry across that boundary. For this reason the checks use long carry chains and alternating bit patterns, so that each nibble boundary and each group term decides the result.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Pair of group lookahead signals passed from one level to the next
   typedef struct packed {
      logic prop;
      logic gen;
   } grp_sig_t;

   localparam int unsigned DEF_WIDTH = 16;
   localparam int unsigned DEF_GROUP = 4;
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic p_o,
   output logic g_o
);
   assign g_o = a_i & b_i;
   assign p_o = a_i ^ b_i;
   assign s_o = p_o ^ c_i;

   always_comb begin
      AST_PG_EXCLUSIVE: assert (!(p_o && g_o)) else $error("propagate and generate both high"); // R1
      AST_SUM_FROM_CARRY: assert (s_o == ((a_i | b_i) & ~(a_i & b_i)) ^ c_i) else $error("sum bit mismatch"); // R2
   end
endmodule

// File: rtl/cla_lookahead_unit.sv
module cla_lookahead_unit #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] p_i,
   input  logic [N-1:0] g_i,
   input  logic         c_i,
   output logic [N:1]   carry_o,
   output logic         grp_p_o,
   output logic         grp_g_o
);
   if (N < 2 || N > 8) begin : g_bad_n
      $error("cla_lookahead_unit: N must be between 2 and 8");
   end

   // Each carry is a flat OR of product terms; no carry feeds another
   always_comb begin
      for (int k = 1; k <= N; k++) begin
         logic acc;
         logic prod;
         acc = 1'b0;
         for (int j = 0; j < k; j++) begin
            prod = g_i[j];
            for (int m = j + 1; m < k; m++) prod = prod & p_i[m];
            acc = acc | prod;
         end
         prod = c_i;
         for (int m = 0; m < k; m++) prod = prod & p_i[m];
         carry_o[k] = acc | prod;
      end
   end

   always_comb begin
      logic acc;
      logic prod;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         prod = g_i[j];
         for (int m = j + 1; m < N; m++) prod = prod & p_i[m];
         acc = acc | prod;
      end
      grp_g_o = acc;
      grp_p_o = &p_i;
   end

   // Flat form must agree with the one-step recursion
   always_comb begin
      AST_FIRST_CARRY: assert (carry_o[1] == (g_i[0] | (p_i[0] & c_i))) else $error("c1 mismatch"); // R3
      for (int k = 1; k < N; k++) begin
         AST_CARRY_RECURSION: assert (carry_o[k+1] == (g_i[k] | (p_i[k] & carry_o[k]))) else $error("carry recursion mismatch"); // R3
      end
      AST_GROUP_EXCLUSIVE: assert (!(grp_p_o && grp_g_o)) else $error("group p and g both high"); // R4
      AST_GROUP_GEN: assert (grp_g_o == (carry_o[N] & ~(c_i & grp_p_o)) || grp_g_o == carry_o[N]) else $error("group generate mismatch"); // R5
   end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
   parameter int unsigned WIDTH = cla_pkg::DEF_WIDTH,
   parameter int unsigned GROUP = cla_pkg::DEF_GROUP
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out,
   output logic             grp_prop,
   output logic             grp_gen
);
   import cla_pkg::*;

   localparam int unsigned NGRP = WIDTH / GROUP;

   if (WIDTH != GROUP * GROUP) begin : g_bad_shape
      $error("cla_adder16: WIDTH must equal GROUP*GROUP for a two-level tree");
   end

   logic [WIDTH-1:0] bit_p;
   logic [WIDTH-1:0] bit_g;
   logic [WIDTH-1:0] bit_c;
   grp_sig_t [NGRP-1:0] grp_sig;
   logic [NGRP-1:0] grp_p_vec;
   logic [NGRP-1:0] grp_g_vec;
   logic [NGRP-1:0] nib_cin;
   logic [NGRP-1:0] nib_cout;
   logic [NGRP:1]   top_carry;

   for (genvar gi = 0; gi < NGRP; gi++) begin : g_nib
      logic [GROUP:1] loc_carry;
      logic lp;
      logic lg;

      if (gi == 0) begin : g_first
         assign nib_cin[gi] = carry_in;
      end else begin : g_rest
         assign nib_cin[gi] = top_carry[gi];
      end

      cla_lookahead_unit #(.N(GROUP)) i_la1 (
         .p_i     (bit_p[gi*GROUP +: GROUP]),
         .g_i     (bit_g[gi*GROUP +: GROUP]),
         .c_i     (nib_cin[gi]),
         .carry_o (loc_carry),
         .grp_p_o (lp),
         .grp_g_o (lg)
      );

      assign grp_sig[gi].prop = lp;
      assign grp_sig[gi].gen  = lg;
      assign nib_cout[gi]     = loc_carry[GROUP];

      for (genvar bi = 0; bi < GROUP; bi++) begin : g_bit
         if (bi == 0) begin : g_b0
            assign bit_c[gi*GROUP + bi] = nib_cin[gi];
         end else begin : g_bn
            assign bit_c[gi*GROUP + bi] = loc_carry[bi];
         end

         cla_bit_cell i_cell (
            .a_i (op_a[gi*GROUP + bi]),
            .b_i (op_b[gi*GROUP + bi]),
            .c_i (bit_c[gi*GROUP + bi]),
            .s_o (sum_out[gi*GROUP + bi]),
            .p_o (bit_p[gi*GROUP + bi]),
            .g_o (bit_g[gi*GROUP + bi])
         );
      end
   end

   for (genvar gi = 0; gi < NGRP; gi++) begin : g_unpack
      assign grp_p_vec[gi] = grp_sig[gi].prop;
      assign grp_g_vec[gi] = grp_sig[gi].gen;
   end

   cla_lookahead_unit #(.N(NGRP)) i_la2 (
      .p_i     (grp_p_vec),
      .g_i     (grp_g_vec),
      .c_i     (carry_in),
      .carry_o (top_carry),
      .grp_p_o (grp_prop),
      .grp_g_o (grp_gen)
   );

   assign carry_out = top_carry[NGRP];

   always_comb begin
      for (int k = 0; k < NGRP; k++) begin
         AST_NIBBLE_CARRY_AGREE: assert (nib_cout[k] == top_carry[k+1]) else $error("nibble carry disagrees with second level"); // R6
      end
      AST_FULL_SUM: assert ({carry_out, sum_out} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})) else $error("sum mismatch"); // R7
      AST_GRP_PROP: assert (grp_prop == &(op_a ^ op_b)) else $error("group propagate mismatch"); // R4
   end
endmodule

// File: tb/test_cla_adder16.sv
module test_cla_adder16;
   logic        clk = 1'b0;
   logic [15:0] op_a = '0;
   logic [15:0] op_b = '0;
   logic        carry_in = 1'b0;
   logic [15:0] sum_out;
   logic        carry_out;
   logic        grp_prop;
   logic        grp_gen;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cla_adder16 i_cla_adder16 (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum_out   (sum_out),
      .carry_out (carry_out),
      .grp_prop  (grp_prop),
      .grp_gen   (grp_gen)
   );

   // {a, b, cin, expected 17-bit result}
   localparam int NV = 13;
   localparam logic [49:0] VEC [NV] = '{
      {16'h0000, 16'h0000, 1'b0, 17'h00000},
      {16'hFFFF, 16'h0001, 1'b0, 17'h10000},
      {16'h000F, 16'h0001, 1'b0, 17'h00010},
      {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
      {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
      {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
      {16'h5555, 16'h5555, 1'b0, 17'h0AAAA},
      {16'hAAAA, 16'hAAAA, 1'b0, 17'h15554},
      {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
      {16'h1234, 16'h4321, 1'b0, 17'h05555},
      {16'h8000, 16'h8000, 1'b0, 17'h10000},
      {16'h00FF, 16'h0001, 1'b0, 17'h00100},
      {16'h0FFF, 16'h0001, 1'b0, 17'h01000}
   };

   task automatic check17(input string req, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h", req, op_a, op_b, carry_in, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
      @(negedge clk);
      op_a = a;
      op_b = b;
      carry_in = c;
      #1;
   endtask

   task automatic check_group(input string req);
      logic [16:0] plain;
      plain = {1'b0, op_a} + {1'b0, op_b};
      check17({req, " grp_prop R4"}, {16'h0, grp_prop}, {16'h0, &(op_a ^ op_b)});
      check17({req, " grp_gen R5"}, {16'h0, grp_gen}, {16'h0, plain[16]});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // Initial state: zero inputs give zero outputs (R7)
      #1;
      check17("R7 initial", {carry_out, sum_out}, 17'h0);

      // Table walk: R7 and the worst-case ripple patterns of R8
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
         check17("R7/R8 table", {carry_out, sum_out}, VEC[i][16:0]);
         check_group("table");
      end

      // R9: no clock edge needed, outputs follow inputs in the same time step
      @(negedge clk);
      op_a = 16'hFFFF; op_b = 16'h0001; carry_in = 1'b0;
      #0.5;
      check17("R9 settle without clock", {carry_out, sum_out}, 17'h10000);
      op_b = 16'h0000;
      #0.5;
      check17("R9 settle without clock", {carry_out, sum_out}, 17'h0FFFF);

      // R2/R3/R6: carry entering each nibble boundary through the tree
      for (int n = 0; n < 4; n++) begin
         logic [15:0] a;
         a = 16'hFFFF >> (4 * (3 - n));
         apply(a, 16'h0001, 1'b0);
         check17("R2/R3/R6 boundary", {carry_out, sum_out}, {1'b0, a} + 17'd1);
         apply(a, 16'h0000, 1'b1);
         check17("R6 carry_in into chain", {carry_out, sum_out}, {1'b0, a} + 17'd1);
      end

      // R1: bits set in both operands generate, so doubling shifts left
      apply(16'h0F0F, 16'h0F0F, 1'b0);
      check17("R1 generate doubling", {carry_out, sum_out}, 17'h01E1E);

      // R7: random vectors against behavioural addition
      for (int i = 0; i < 6000; i++) begin
         logic [15:0] a;
         logic [15:0] b;
         logic c;
         a = 16'($urandom);
         b = 16'($urandom);
         c = 1'($urandom);
         apply(a, b, c);
         check17("R7 random", {carry_out, sum_out}, {1'b0, a} + {1'b0, b} + {16'h0, c});
         if (i % 16 == 0) check_group("random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule